// File: doc/BRIEF.md
# Guarded Bus-Sharing Mode Register

This block is an 8-bit control register on a simple write bus. The bus carries an address, write data, a write strobe and a tag that names the bus master issuing the write. The register's single functional bit chooses how two CAN controllers reach the outside world. When the bit is clear, each controller drives and samples its own pin pair. When it is set, both controllers are joined onto one shared pin pair. A controller that loses internal arbitration then acts as a receiver on the shared bus.

A two-write unlock sequence guards the mode bit against stray writes.

- The first write to the register carries the arm flag. It changes nothing except to arm the sequence.
- The very next qualifying write carries the arm flag clear and supplies the new mode value.
- A write from an ordinary master to any other address between the two steps cancels the sequence.
- Writes from masters on an exempt list do not cancel it.

The new mode value is accepted only while both controllers hold their reset-request flags. Each accepted load raises a one-cycle pulse.

Top module: `guarded_mode_reg`

## Requirements
- R1: During and directly after a synchronous active-low reset, rd_data is 0x00, share_mode is 0 and upd_pulse is 0.
- R2: rd_data bits 6..0 always read 0; bit 7 equals share_mode. Bits 5..0 of a write have no effect.
- R3: A write to the register address with data bit 6 = 1 arms the sequence without changing bit 7. If the next write to the register address has bit 6 = 0 and both reset-request flags are 1 in that cycle, it loads data bit 7 into share_mode, visible one cycle after the write cycle.
- R4: While the sequence is armed, a write to any other address by a master whose tag bit in EXEMPT_MASK is 0 disarms it, so the following bit-6 = 0 write to the register loads nothing.
- R5: A write to another address by a master whose tag bit in EXEMPT_MASK is 1 leaves an armed sequence armed.
- R6: A step-two write made while ctl_a_rst_req or ctl_b_rst_req is 0 loads nothing. It still disarms the sequence.
- R7: A bit-6 = 0 write to the register while the sequence is not armed leaves share_mode unchanged.
- R8: A bit-6 = 1 write while already armed keeps the sequence armed and does not change share_mode.
- R9: upd_pulse is high for exactly the one cycle after each accepted load. share_mode never changes without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data; bit 7 = mode value, bit 6 = arm flag |
| wr_master | input | MTAG_W | Tag of the master issuing the write |
| ctl_a_rst_req | input | 1 | Reset-request flag of the first controller |
| ctl_b_rst_req | input | 1 | Reset-request flag of the second controller |
| rd_data | output | 8 | Register read value |
| share_mode | output | 1 | 1 = controllers share one pin pair, 0 = independent |
| upd_pulse | output | 1 | One-cycle pulse after an accepted mode load |

## Verification
The assertions assume that every input, including the master tag and the reset-request flags, is stable and defined around each rising edge. They also assume a write lasts exactly one strobe-high cycle, and that the tag always indexes a real entry of the exempt mask. The bench changes every input only on the falling edge. It lowers the strobe after each single-cycle write, uses only tags inside the mask, and changes the reset-request flags only between writes, never within one.

// File: rtl/gmr_pkg.sv
// Shared definitions for the guarded mode register.
// Assumes an 8-bit register whose mode and arm-flag positions are fixed.
package gmr_pkg;
    localparam int REG_W    = 8;
    localparam int ARM_BIT  = 6;
    localparam int MODE_BIT = 7;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } unlock_st_e;

    // Classification of the write seen in the current cycle
    typedef struct packed {
        logic own;            // write that targets this register
        logic foreign_cancel; // write elsewhere by a non-exempt master
    } wr_class_t;
endpackage

// File: rtl/gmr_decode.sv
// Write classifier: compares the address against the register address and
// looks the master tag up in the exempt mask.
// Assumes the mask has one bit per possible tag value.
module gmr_decode
    import gmr_pkg::*;
#(
    parameter int                      ADDR_W      = 16,
    parameter int                      MTAG_W      = 3,
    parameter logic [ADDR_W-1:0]       REG_ADDR    = '0,
    parameter logic [(1<<MTAG_W)-1:0]  EXEMPT_MASK = '0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [MTAG_W-1:0] wr_master,
    output wr_class_t         cls
);
    localparam int NUM_MASTERS = 1 << MTAG_W;

    logic [NUM_MASTERS-1:0] exempt_hit;
    logic                   exempt;
    logic                   addr_hit;

    // One comparator per tag value that the mask marks as exempt
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_exempt
        if (EXEMPT_MASK[m]) begin : g_on
            assign exempt_hit[m] = (wr_master == MTAG_W'(m));
        end else begin : g_off
            assign exempt_hit[m] = 1'b0;
        end
    end

    // Reduce the per-tag hits and compare the address
    always_comb begin
        exempt             = |exempt_hit;
        addr_hit           = (wr_addr == REG_ADDR);
        cls.own            = wr_en && addr_hit;
        cls.foreign_cancel = wr_en && !addr_hit && !exempt;
    end
endmodule

// File: rtl/gmr_unlock.sv
// Unlock sequencer: tracks whether step one has been seen and flags a
// step-two write. Assumes classified writes from gmr_decode.
module gmr_unlock
    import gmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wr_class_t cls,
    input  logic      arm_flag,
    output logic      armed,
    output logic      step_two
);
    unlock_st_e st_q, st_d;

    // Next state: own writes re-arm or disarm, foreign writes cancel
    always_comb begin
        st_d = st_q;
        if (cls.own) begin
            st_d = arm_flag ? ST_ARMED : ST_IDLE;
        end else if (cls.foreign_cancel) begin
            st_d = ST_IDLE;
        end
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Step two is an own write with the arm flag clear while armed
    always_comb begin
        armed    = (st_q == ST_ARMED);
        step_two = cls.own && !arm_flag && armed;
    end
endmodule

// File: rtl/gmr_mode_store.sv
// Mode bit storage: loads the new mode on an accepted step two and
// registers a one-cycle update pulse. Assumes step_two lasts one cycle.
module gmr_mode_store (
    input  logic clk,
    input  logic rst_n,
    input  logic step_two,
    input  logic both_ready,
    input  logic new_mode,
    output logic mode_q,
    output logic upd_q
);
    logic accept;

    // A load is accepted only while both controllers request reset
    always_comb accept = step_two && both_ready;

    // Mode bit and update pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= accept;
            if (accept) mode_q <= new_mode;
        end
    end
endmodule

// File: rtl/guarded_mode_reg.sv
// Guarded bus-sharing mode register: top level.
// Holds one mode bit behind a two-write unlock sequence.
// Assumes single-cycle writes and one address compare for decode.
module guarded_mode_reg
    import gmr_pkg::*;
#(
    parameter int                      ADDR_W      = 16,
    parameter int                      MTAG_W      = 3,
    parameter logic [ADDR_W-1:0]       REG_ADDR    = 16'h0A2C,
    parameter logic [(1<<MTAG_W)-1:0]  EXEMPT_MASK = 8'b0000_1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [MTAG_W-1:0] wr_master,
    input  logic              ctl_a_rst_req,
    input  logic              ctl_b_rst_req,
    output logic [7:0]        rd_data,
    output logic              share_mode,
    output logic              upd_pulse
);
    wr_class_t cls;
    logic      armed_q;
    logic      step_two;
    logic      mode_q;
    logic      upd_q;

    gmr_decode #(
        .ADDR_W      (ADDR_W),
        .MTAG_W      (MTAG_W),
        .REG_ADDR    (REG_ADDR),
        .EXEMPT_MASK (EXEMPT_MASK)
    ) u_decode (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_master (wr_master),
        .cls       (cls)
    );

    gmr_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .cls      (cls),
        .arm_flag (wr_data[ARM_BIT]),
        .armed    (armed_q),
        .step_two (step_two)
    );

    gmr_mode_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_two   (step_two),
        .both_ready (ctl_a_rst_req && ctl_b_rst_req),
        .new_mode   (wr_data[MODE_BIT]),
        .mode_q     (mode_q),
        .upd_q      (upd_q)
    );

    // Read value: only the mode bit is ever nonzero
    always_comb begin
        rd_data           = '0;
        rd_data[MODE_BIT] = mode_q;
        share_mode        = mode_q;
        upd_pulse         = upd_q;
    end
endmodule

// File: rtl/gmr_checker.sv
// Property checker for guarded_mode_reg, attached through bind.
// Assumes inputs settle before each rising edge.
module gmr_checker #(
    parameter int                      ADDR_W      = 16,
    parameter int                      MTAG_W      = 3,
    parameter logic [ADDR_W-1:0]       REG_ADDR    = '0,
    parameter logic [(1<<MTAG_W)-1:0]  EXEMPT_MASK = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [MTAG_W-1:0] wr_master,
    input logic              ctl_a_rst_req,
    input logic              ctl_b_rst_req,
    input logic [7:0]        rd_data,
    input logic              share_mode,
    input logic              upd_pulse,
    input logic              armed
);
    // R2
    readback_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == {share_mode, 7'b0});

    // R3
    arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_ADDR && wr_data[6]) |=> armed);

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_ADDR && !wr_data[6] && armed
         && ctl_a_rst_req && ctl_b_rst_req) |=> (share_mode == $past(wr_data[7])));

    // R4
    foreign_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != REG_ADDR && !EXEMPT_MASK[wr_master]) |=> !armed);

    // R6
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_ADDR && !(ctl_a_rst_req && ctl_b_rst_req))
        |=> (!upd_pulse && $stable(share_mode)));

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |=> !upd_pulse);

    // R9
    mode_change_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(share_mode) |-> upd_pulse);
endmodule

bind guarded_mode_reg gmr_checker #(
    .ADDR_W      (ADDR_W),
    .MTAG_W      (MTAG_W),
    .REG_ADDR    (REG_ADDR),
    .EXEMPT_MASK (EXEMPT_MASK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .wr_master     (wr_master),
    .ctl_a_rst_req (ctl_a_rst_req),
    .ctl_b_rst_req (ctl_b_rst_req),
    .rd_data       (rd_data),
    .share_mode    (share_mode),
    .upd_pulse     (upd_pulse),
    .armed         (armed_q)
);

// File: tb/guarded_mode_reg_tb.sv
`timescale 1ns/1ps
module guarded_mode_reg_tb;
    localparam logic [15:0] OWN   = 16'h0A2C;
    localparam logic [15:0] OTHER = 16'h0A30;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic [2:0]  wr_master;
    logic        fa, fb;
    logic [7:0]  rd_data;
    logic        share_mode;
    logic        upd_pulse;

    always #4 clk = ~clk;

    guarded_mode_reg u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .wr_master     (wr_master),
        .ctl_a_rst_req (fa),
        .ctl_b_rst_req (fb),
        .rd_data       (rd_data),
        .share_mode    (share_mode),
        .upd_pulse     (upd_pulse)
    );

    typedef struct {
        logic [7:0] rd;
        logic       pulse;
        int         due;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t mon_e;
    int   total = 0;
    int   bad   = 0;
    int   cyc   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver: one bus cycle, expectation due at the next falling edge
    task automatic step(input logic en, input logic [15:0] a, input logic [7:0] d,
                        input logic [2:0] m, input logic ra, input logic rb,
                        input logic [7:0] exp_rd, input logic exp_p, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d; wr_master = m; fa = ra; fb = rb;
        e.rd = exp_rd; e.pulse = exp_p; e.due = cyc + 1; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: pops expectations that fall due and compares
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            mon_e = q.pop_front();
            total++;
            if (rd_data !== mon_e.rd || upd_pulse !== mon_e.pulse
                || share_mode !== mon_e.rd[7]) begin
                bad++;
                $display("FAIL %s: rd=%h pulse=%b mode=%b expected rd=%h pulse=%b mode=%b",
                         mon_e.tag, rd_data, upd_pulse, share_mode,
                         mon_e.rd, mon_e.pulse, mon_e.rd[7]);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_master = '0;
        fa = 1'b1; fb = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (rd_data !== 8'h00 || share_mode !== 1'b0 || upd_pulse !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: rd=%h mode=%b pulse=%b expected 00 0 0",
                     rd_data, share_mode, upd_pulse);
        end
        rst_n = 1'b1;
        step(0, OWN, 8'h00, 0, 1, 1, 8'h00, 0, "R1 after release");
        // R3 basic unlock then load
        step(1, OWN, 8'h40, 0, 1, 1, 8'h00, 0, "R3 arm");
        step(1, OWN, 8'h80, 0, 1, 1, 8'h80, 1, "R3 load 1");
        step(0, OWN, 8'h00, 0, 1, 1, 8'h80, 0, "R9 pulse one cycle");
        // R2 junk low bits ignored, bit 6 reads 0
        step(1, OWN, 8'h7F, 0, 1, 1, 8'h80, 0, "R2 arm junk bits");
        step(1, OWN, 8'h3F, 0, 1, 1, 8'h00, 1, "R2 load 0 junk bits");
        // R7 unarmed write
        step(1, OWN, 8'h80, 0, 1, 1, 8'h00, 0, "R7 unarmed no change");
        // R4 non-exempt foreign write cancels
        step(1, OWN,   8'h40, 0, 1, 1, 8'h00, 0, "R4 arm");
        step(1, OTHER, 8'h00, 1, 1, 1, 8'h00, 0, "R4 foreign write");
        step(1, OWN,   8'h80, 0, 1, 1, 8'h00, 0, "R4 cancelled load");
        // R5 exempt foreign write does not cancel
        step(1, OWN,   8'h40, 0, 1, 1, 8'h00, 0, "R5 arm");
        step(1, OTHER, 8'hFF, 2, 1, 1, 8'h00, 0, "R5 exempt write");
        step(1, OWN,   8'h80, 1, 1, 1, 8'h80, 1, "R5 load survives");
        // R8 re-arm keeps mode
        step(1, OWN, 8'h40, 3, 1, 1, 8'h80, 0, "R8 arm");
        step(1, OWN, 8'hC0, 0, 1, 1, 8'h80, 0, "R8 re-arm no change");
        step(1, OWN, 8'h00, 0, 1, 1, 8'h00, 1, "R8 load after re-arm");
        // R6 flag A clear: discarded and disarmed
        step(1, OWN, 8'h40, 0, 0, 1, 8'h00, 0, "R6 arm flag A low");
        step(1, OWN, 8'h80, 0, 0, 1, 8'h00, 0, "R6 discarded A");
        step(1, OWN, 8'h80, 0, 1, 1, 8'h00, 0, "R6 disarmed after discard");
        // R6 flag B clear
        step(1, OWN, 8'h40, 0, 1, 0, 8'h00, 0, "R6 arm flag B low");
        step(1, OWN, 8'h80, 0, 1, 0, 8'h00, 0, "R6 discarded B");
        step(0, OWN, 8'h00, 0, 1, 1, 8'h00, 0, "R9 no pulse idle");
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule